// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte Writes

This block is a single-port synchronous static memory with a flow-through read path. Each word is 18 bits wide and is split into two 9-bit lanes. Each lane holds eight data bits and one parity bit that the memory stores like any other bit. The address, the write data, the three chip selects, the two address strobes, the advance input and the write controls are all captured on the rising clock edge. Read data for the address held in the address register leaves the array combinationally, in the same cycle, with no output register. The output enable gates the read data and the valid flag asynchronously.

A burst begins when a load strobe is seen. The processor-side strobe wins over the controller-side strobe, and the processor strobe only counts while the primary chip select is asserted. A load captures a base address and the select state. Later beats come from a 2-bit beat counter that the advance input steps. That counter changes only the two lowest address bits, in linear or interleaved order, and it wraps after four beats. The block is controlled by a three-state machine. `ST_DESEL` means the device is not selected. `ST_READ` means the current cycle is a read. `ST_WRITE` means the current cycle wrote the array. The transitions are: a selected load goes to `ST_READ` or `ST_WRITE`; a deselected load goes to `ST_DESEL`; in a selected state, a cycle with no load goes to `ST_WRITE` when any lane is enabled and to `ST_READ` otherwise; `ST_DESEL` stays put until the next load. The byte-lane write enables are built in layers. A global write enables both lanes. Without it, each lane enable counts only while the byte-write master enable is low.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset the block is deselected, with `rvalid` = 0 and `rdata` = 0.
- R2: A load selects the device only when `cs_n`=0, `cs_hi`=1 and `cs_lo_n`=0. After a deselected load, `rvalid` stays 0 and no write reaches the array until the next selected load, even when advance or write controls are active.
- R3: `adsp_n`=0 while `cs_n`=0 loads `addr` as a read cycle, and all write controls are ignored on that edge. `adsp_n`=0 while `cs_n`=1 is ignored, and the current address is kept.
- R4: `adsc_n`=0, when no processor load is taken, loads `addr`. The write controls sampled on that same edge write the loaded address.
- R5: When both strobes are low and `cs_n`=0, the processor strobe wins, so the cycle is a read even if write controls are active.
- R6: In a selected state with no load, `adv_n`=0 steps the beat counter by one and `adv_n`=1 holds the address. The write controls of that edge decide whether the cycle reads or writes.
- R7: The low two address bits are base+beat modulo 4 when `burst_linear`=1, and base XOR beat when `burst_linear`=0. The upper address bits never change inside a burst, so the burst wraps to the start after four beats.
- R8: Lane 0 is `wdata[8:0]` (bit 8 is parity) and is enabled by `bw_n[0]`=0. Lane 1 is `wdata[17:9]` (bit 17 is parity) and is enabled by `bw_n[1]`=0. Lane enables have no effect unless `bwe_n`=0.
- R9: `gw_n`=0 writes both lanes, whatever the values of `bwe_n` and `bw_n`.
- R10: After an edge that registers a read, `rdata` shows the word at the registered address in that same cycle with `rvalid`=1. A cycle that wrote shows `rvalid`=0 and `rdata`=0.
- R11: `oe_n`=1 forces `rvalid`=0 and `rdata`=0 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state |
| addr | input | AW | Word address, AW = log2(DEPTH) |
| wdata | input | 18 | Write data, two 9-bit lanes |
| cs_n | input | 1 | Primary chip select, active low |
| cs_hi | input | 1 | Depth-expansion select, active high |
| cs_lo_n | input | 1 | Depth-expansion select, active low |
| adsp_n | input | 1 | Processor-side load strobe, active low |
| adsc_n | input | 1 | Controller-side load strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| bwe_n | input | 1 | Byte-write master enable, active low |
| bw_n | input | 2 | Per-lane write enables, active low |
| gw_n | input | 1 | Global write, active low |
| burst_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| rdata | output | 18 | Flow-through read data |
| rvalid | output | 1 | Read data valid |

## Verification
The assertions assume three things about the inputs. First, `burst_linear` is held steady across the cycles that an address-step property spans. Second, every input is driven to a known level from the first clock edge after reset. Third, no strobe or advance input is driven to X. The stimulus respects all three. It changes inputs only on the falling edge and keeps every control at a defined idle level between operations. It changes the burst order only between bursts, right before a new load. Reads go only to addresses that an earlier global write has filled, so no uninitialised word is ever compared.

// File: rtl/sramb_pkg.sv
package sramb_pkg;
    localparam int LANE_W = 9;
    localparam int LANES  = 2;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } cyc_e;
endpackage

// File: rtl/sramb_addr_gen.sv
module sramb_addr_gen #(
    parameter int AW = 10
) (
    input  logic [AW-1:0] base,
    input  logic [1:0]    beat,
    input  logic          linear,
    output logic [AW-1:0] addr
);
    logic [1:0] low;

    always_comb begin
        if (linear) low = base[1:0] + beat;
        else        low = base[1:0] ^ beat;
    end

    assign addr = {base[AW-1:2], low};
endmodule

// File: rtl/sramb_byte_ctrl.sv
module sramb_byte_ctrl #(
    parameter int NB = 2
) (
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    output logic [NB-1:0] be
);
    for (genvar g = 0; g < NB; g++) begin : g_lane
        assign be[g] = ~gw_n | (~bwe_n & ~bw_n[g]);
    end
endmodule

// File: rtl/sramb_array.sv
module sramb_array #(
    parameter int DEPTH = 1024,
    parameter int NB    = 2,
    parameter int BW    = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int DW   = NB * BW
) (
    input  logic          clk,
    input  logic [NB-1:0] we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [BW-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) cells[waddr] <= wdata[g*BW +: BW];
        end

        assign rdata[g*BW +: BW] = cells[raddr];
    end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
    parameter int DEPTH = 1024,
    parameter int NB    = sramb_pkg::LANES,
    parameter int BW    = sramb_pkg::LANE_W,
    localparam int AW   = $clog2(DEPTH),
    localparam int DW   = NB * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          cs_n,
    input  logic          cs_hi,
    input  logic          cs_lo_n,
    input  logic          adsp_n,
    input  logic          adsc_n,
    input  logic          adv_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    input  logic          gw_n,
    input  logic          burst_linear,
    input  logic          oe_n,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    import sramb_pkg::*;

    cyc_e          state, state_n;
    logic [AW-1:0] base_q, base_n;
    logic [1:0]    beat_q, beat_n;
    logic [AW-1:0] addr_q, addr_n;
    logic [NB-1:0] be;
    logic [NB-1:0] arr_we;
    logic [DW-1:0] arr_rd;
    logic          sel_in, take_p, take_c;

    sramb_byte_ctrl #(.NB(NB)) u_bctl (
        .gw_n  (gw_n),
        .bwe_n (bwe_n),
        .bw_n  (bw_n),
        .be    (be)
    );

    sramb_addr_gen #(.AW(AW)) u_agen (
        .base   (base_n),
        .beat   (beat_n),
        .linear (burst_linear),
        .addr   (addr_n)
    );

    sramb_array #(.DEPTH(DEPTH), .NB(NB), .BW(BW)) u_arr (
        .clk   (clk),
        .we    (arr_we),
        .waddr (addr_n),
        .wdata (wdata),
        .raddr (addr_q),
        .rdata (arr_rd)
    );

    // Load decode: processor strobe needs primary select and wins over controller strobe
    assign sel_in = ~cs_n & cs_hi & ~cs_lo_n;
    assign take_p = ~adsp_n & ~cs_n;
    assign take_c = ~take_p & ~adsc_n;

    // Next-state logic
    always_comb begin
        state_n = state;
        base_n  = base_q;
        beat_n  = beat_q;
        if (take_p || take_c) begin
            base_n = addr;
            beat_n = 2'd0;
            if (!sel_in)              state_n = ST_DESEL;
            else if (take_c && |be)   state_n = ST_WRITE;
            else                      state_n = ST_READ;
        end else begin
            unique case (state)
                ST_DESEL: state_n = ST_DESEL;
                ST_READ, ST_WRITE: begin
                    if (!adv_n) beat_n = beat_q + 2'd1;
                    state_n = (|be) ? ST_WRITE : ST_READ;
                end
                default: state_n = ST_DESEL;
            endcase
        end
    end

    assign arr_we = (state_n == ST_WRITE) ? be : '0;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_DESEL;
            base_q <= '0;
            beat_q <= 2'd0;
            addr_q <= '0;
        end else begin
            state  <= state_n;
            base_q <= base_n;
            beat_q <= beat_n;
            addr_q <= addr_n;
        end
    end

    // Outputs: flow-through read gated by output enable
    always_comb begin
        rvalid = (state == ST_READ) && !oe_n;
        rdata  = rvalid ? arr_rd : '0;
    end

    assert_gw_both_lanes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !gw_n |-> (be == '1));

    assert_master_gates_lanes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_n && bwe_n) |-> (be == '0));

    assert_oe_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!rvalid && rdata == '0));

    assert_desel_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (((!adsp_n && !cs_n) || !adsc_n) && !(!cs_n && cs_hi && !cs_lo_n)) |=> !rvalid);

    assert_proc_load_reads_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !cs_n && cs_hi && !cs_lo_n && !oe_n) |=> (rvalid || oe_n));

    assert_hold_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n && adsc_n && adv_n && burst_linear == $past(burst_linear)) |=> $stable(addr_q));

    assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adsp_n && adsc_n) |=> (addr_q[AW-1:2] == $past(addr_q[AW-1:2])));

    assert_linear_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_DESEL && adsp_n && adsc_n && !adv_n && burst_linear && $past(burst_linear))
        |=> (addr_q[1:0] == $past(addr_q[1:0]) + 2'd1));
endmodule

// File: tb/sync_burst_sram_test.sv
`timescale 1ns/1ps
module sync_burst_sram_test;
    localparam int DEPTH = 1024;
    localparam int AW    = $clog2(DEPTH);
    localparam int DW    = 18;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          cs_n, cs_hi, cs_lo_n, adsp_n, adsc_n, adv_n, bwe_n, gw_n;
    logic [1:0]    bw_n;
    logic          burst_linear, oe_n;
    logic [DW-1:0] rdata;
    logic          rvalid;

    always #2 clk = ~clk;

    sync_burst_sram #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .cs_n(cs_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
        .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .gw_n(gw_n),
        .burst_linear(burst_linear), .oe_n(oe_n),
        .rdata(rdata), .rvalid(rvalid)
    );

    typedef struct {
        logic          v;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;

    exp_t sbq[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 0;

    // Reference model state
    logic [DW-1:0] m_mem [DEPTH];
    int            m_st = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_beat = 2'd0;

    task automatic set_idle();
        addr = '0; wdata = '0;
        cs_n = 1'b0; cs_hi = 1'b1; cs_lo_n = 1'b0;
        adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
        bwe_n = 1'b1; bw_n = 2'b11; gw_n = 1'b1; oe_n = 1'b0;
    endtask

    // Driver: model the edge from the requirements, push expectation, advance one cycle
    task automatic step(input string tag);
        logic sel, tp, tc, b0, b1;
        logic [1:0] low;
        logic [AW-1:0] a;
        exp_t e;
        sel = !cs_n && cs_hi && !cs_lo_n;
        tp  = !adsp_n && !cs_n;
        tc  = !tp && !adsc_n;
        b0  = !gw_n || (!bwe_n && !bw_n[0]);
        b1  = !gw_n || (!bwe_n && !bw_n[1]);
        if (tp || tc) begin
            m_base = addr; m_beat = 2'd0;
            m_st = !sel ? 0 : ((tc && (b0 || b1)) ? 2 : 1);
        end else if (m_st != 0) begin
            if (!adv_n) m_beat = m_beat + 2'd1;
            m_st = (b0 || b1) ? 2 : 1;
        end
        low = burst_linear ? (m_base[1:0] + m_beat) : (m_base[1:0] ^ m_beat);
        a   = {m_base[AW-1:2], low};
        if (m_st == 2) begin
            if (b0) m_mem[a][8:0]  = wdata[8:0];
            if (b1) m_mem[a][17:9] = wdata[17:9];
        end
        e.v   = (m_st == 1) && !oe_n;
        e.d   = e.v ? m_mem[a] : '0;
        e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
    endtask

    task automatic ctl_write(input int a, input logic [DW-1:0] d, input string tag);
        set_idle(); adsc_n = 1'b0; addr = AW'(a); wdata = d; gw_n = 1'b0;
        step(tag);
    endtask

    task automatic proc_read(input int a, input string tag);
        set_idle(); adsp_n = 1'b0; addr = AW'(a);
        step(tag);
    endtask

    task automatic advance(input string tag);
        set_idle(); adv_n = 1'b0;
        step(tag);
    endtask

    // Monitor: compare after each edge, well before inputs change
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                n_tests++;
                if (rvalid !== e.v || rdata !== e.d) begin
                    n_fail++;
                    $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                             e.tag, rvalid, rdata, e.v, e.d);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        burst_linear = 1'b1;
        set_idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        n_tests++;
        if (rvalid !== 1'b0 || rdata !== '0) begin
            n_fail++;
            $display("FAIL R1: rvalid=%0b rdata=%h expected rvalid=0 rdata=0", rvalid, rdata);
        end

        // R9 / R4 / R10: fill with global writes through the controller strobe
        for (int i = 0; i < 32; i++) ctl_write(i, DW'(i * 18'h0ABC + 18'h1235), "R9");

        // R3 / R10: single flow-through reads
        proc_read(3, "R3");
        proc_read(17, "R10");

        // R7: linear burst from 5 -> 5,6,7,4 then wrap to 5; R6 hold
        burst_linear = 1'b1;
        proc_read(5, "R7");
        for (int k = 0; k < 4; k++) advance("R7");
        set_idle(); step("R6");

        // R7: interleaved burst from 5 -> 5,4,7,6
        burst_linear = 1'b0;
        proc_read(5, "R7");
        for (int k = 0; k < 3; k++) advance("R7");

        // R7: no carry into upper bits, linear from 31 -> 31,28,29,30
        burst_linear = 1'b1;
        proc_read(31, "R7");
        for (int k = 0; k < 3; k++) advance("R7");

        // R8: low lane only
        set_idle(); adsc_n = 1'b0; addr = AW'(9); wdata = 18'h3FFFF; bwe_n = 1'b0; bw_n = 2'b10;
        step("R8");
        proc_read(9, "R8");
        // R8: high lane only
        set_idle(); adsc_n = 1'b0; addr = AW'(10); wdata = 18'h3FFFF; bwe_n = 1'b0; bw_n = 2'b01;
        step("R8");
        proc_read(10, "R8");
        // R8: lane enables without master enable do nothing
        set_idle(); adsc_n = 1'b0; addr = AW'(11); wdata = 18'h3FFFF; bwe_n = 1'b1; bw_n = 2'b00;
        step("R8");
        proc_read(11, "R8");
        // R9: global write overrides disabled master
        set_idle(); adsc_n = 1'b0; addr = AW'(12); wdata = 18'h2AAAA; bwe_n = 1'b1; bw_n = 2'b11; gw_n = 1'b0;
        step("R9");
        proc_read(12, "R9");

        // R2: deselected loads block output and writes
        set_idle(); adsc_n = 1'b0; cs_hi = 1'b0; addr = AW'(13); wdata = 18'h15555; gw_n = 1'b0;
        step("R2");
        set_idle(); adv_n = 1'b0; gw_n = 1'b0; wdata = 18'h15555;
        step("R2");
        set_idle(); adsc_n = 1'b0; cs_lo_n = 1'b1; addr = AW'(13); wdata = 18'h15555; gw_n = 1'b0;
        step("R2");
        proc_read(13, "R2");

        // R3: processor strobe ignored while primary select is off
        proc_read(20, "R3");
        set_idle(); adsp_n = 1'b0; cs_n = 1'b1; addr = AW'(25);
        step("R3");
        // R3: write controls ignored on a processor load
        set_idle(); adsp_n = 1'b0; addr = AW'(21); wdata = 18'h00F0F; gw_n = 1'b0;
        step("R3");
        proc_read(21, "R3");

        // R5: both strobes -> processor wins, no write
        set_idle(); adsp_n = 1'b0; adsc_n = 1'b0; addr = AW'(22); wdata = 18'h0F0F0; gw_n = 1'b0;
        step("R5");
        proc_read(22, "R5");
        // R4: controller strobe taken when processor strobe is refused
        set_idle(); adsp_n = 1'b0; adsc_n = 1'b0; cs_n = 1'b1; addr = AW'(23); gw_n = 1'b0;
        step("R4");

        // R6: write on an advance beat
        proc_read(24, "R6");
        set_idle(); adv_n = 1'b0; gw_n = 1'b0; wdata = 18'h12345;
        step("R6");
        proc_read(25, "R6");

        // R11: output enable gating
        set_idle(); adsp_n = 1'b0; addr = AW'(26); oe_n = 1'b1;
        step("R11");
        set_idle(); step("R11");

        @(posedge clk);
        #2;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule